// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target (256 x 8)

This block is the target side of a two-wire serial EEPROM with 256 bytes of 8 bits, kept in a register array. SCL and SDA are sampled on a system clock. The block finds bus start and stop conditions, checks the device address byte against three strap inputs, and then handles a one-byte word address, single-byte and page writes, and current-address, random and sequential reads. It drives SDA open-drain through one pull-low output, both to acknowledge and to send read data.

Written bytes collect in a page buffer of up to eight entries. They reach the array only when the controller sends a stop. After that commit a self-timed busy interval runs, and during it the block does not answer its device address. A write-protect input turns page commits into the upper half of the array (0x80 to 0xFF) into no-ops. The lower half stays writable while protection is on.

Top module: `serial_eeprom_tgt`

## Requirements
- R1: A falling SDA with SCL high is a start: from any state it restarts address reception and discards any buffered bytes. A rising SDA with SCL high is a stop: it returns the block to idle with SDA released.
- R2: The device address byte is bits 7..4 = 1010, bits 3..1 = the strap inputs (bit 3 = strap 2), and bit 0 = direction (1 = read). It is acknowledged only when it matches. A non-matching byte is not acknowledged, and all later bits are ignored, with SDA released, until the next start.
- R3: Every received byte is acknowledged by pulling SDA low for the ninth SCL clock. Bits are taken MSB first on the rising SCL edge, and the block changes its own SDA drive only while SCL is low, except when releasing at a start or stop.
- R4: A write of device address, word address, one data byte and stop stores the byte at that word address.
- R5: Page writes take up to 8 bytes. The low 3 address bits advance and wrap inside the 8-byte page, while bits 7..3 stay fixed. Partial pages are allowed. Nothing is committed until the stop.
- R6: A stop that ends a write with at least one data byte starts a busy interval of WRITE_CYCLES clocks. While it runs the device address is not acknowledged, and afterwards it is acknowledged again. A stop with no buffered data starts no interval.
- R7: When write-protect is high at the commit stop, a page at 0x80..0xFF is left unchanged, and a page at 0x00..0x7F is still written.
- R8: Reads return bytes MSB first. Sequential reads advance the full 8-bit address, with 0xFF followed by 0x00. Every sent byte advances the pointer, so a current-address read continues after the last byte sent. A controller no-acknowledge ends the read and SDA stays released.
- R9: After reset SDA is released, the address pointer is 0 and every byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data level seen on the bus |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain), 0 releases it |
| dev_sel_i | input | 3 | Hard-wired device address straps |
| wp_i | input | 1 | Write protect for the upper half |

## Verification
On every cycle the assertions check the following: the block's own SDA drive stays steady while SCL is high, except for start or stop; SDA is released after any stop; a commit happens only on a stop and only when the block is not busy; each commit is followed at once by the busy interval; and the block never acknowledges its address while busy. Other behaviour is only visible in whole transactions, so the bench's scenarios cover it. This includes address matching across all strap codes, page wrap placement, the effect of write protection on array contents, sequential wrap at 0xFF, discarding a page on a repeated start, and the array contents after reset.

// File: rtl/seep_pkg.sv
package seep_pkg;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
  localparam int unsigned FN_W = 16;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DACK,
    ST_WADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK,
    ST_WAIT
  } seep_state_e;

  // device byte: type nibble, strap code, direction bit
  function automatic logic dev_hit(input logic [7:0] b, input logic [2:0] straps);
    return b[7:1] == {DEV_TYPE, straps};
  endfunction

  // next address inside a page: only the bits under mask move
  function automatic logic [FN_W-1:0] page_step(input logic [FN_W-1:0] a,
                                               input logic [FN_W-1:0] mask);
    return (a & ~mask) | ((a + 1'b1) & mask);
  endfunction

  // next address of a sequential read, wrapping at the array top
  function automatic logic [FN_W-1:0] seq_step(input logic [FN_W-1:0] a,
                                              input logic [FN_W-1:0] mask);
    return (a + 1'b1) & mask;
  endfunction

endpackage

// File: rtl/seep_line_sync.sv
module seep_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_d  <= scl_sh[STAGES-1];
      sda_d  <= sda_sh[STAGES-1];
    end
  end

  assign scl_lvl  = scl_sh[STAGES-1];
  assign sda_lvl  = sda_sh[STAGES-1];
  assign scl_rise = scl_lvl & ~scl_d;
  assign scl_fall = ~scl_lvl & scl_d;
  assign start_ev = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_ev  = scl_lvl & scl_d & ~sda_d & sda_lvl;

endmodule

// File: rtl/seep_link.sv
module seep_link
  import seep_pkg::*;
#(
  parameter int DEPTH      = 256,
  parameter int PAGE_BYTES = 8,
  localparam int AW        = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_ev,
  input  logic          stop_ev,
  input  logic [2:0]    straps,
  input  logic          busy,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          buf_we,
  output logic [AW-1:0] buf_addr,
  output logic [7:0]    buf_data,
  output logic          sda_pull,
  output logic          dev_acking
);

  localparam logic [FN_W-1:0] PAGE_MASK = FN_W'(PAGE_BYTES - 1);
  localparam logic [FN_W-1:0] ADDR_MASK = FN_W'(DEPTH - 1);

  seep_state_e   state;
  logic [3:0]    cnt;
  logic [7:0]    sr;
  logic [7:0]    shreg;
  logic          rw;
  logic [AW-1:0] ptr;

  wire rx_state = (state == ST_DEV) || (state == ST_WADDR) || (state == ST_WDATA);
  wire byte_end = scl_fall && (cnt == 4'd8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      sr       <= '0;
      shreg    <= 8'hFF;
      rw       <= 1'b0;
      ptr      <= '0;
      buf_we   <= 1'b0;
      buf_addr <= '0;
      buf_data <= '0;
    end else begin
      buf_we <= 1'b0;
      if (start_ev) begin
        state <= ST_DEV;
        cnt   <= '0;
      end else if (stop_ev) begin
        state <= ST_IDLE;
      end else if (rx_state) begin
        if (scl_rise) begin
          sr  <= {sr[6:0], sda_lvl};
          cnt <= cnt + 4'd1;
        end else if (byte_end) begin
          cnt <= '0;
          if (state == ST_DEV) begin
            if (dev_hit(sr, straps) && !busy) begin
              rw    <= sr[0];
              state <= ST_DACK;
            end else begin
              state <= ST_WAIT;
            end
          end else if (state == ST_WADDR) begin
            ptr   <= sr[AW-1:0];
            state <= ST_AACK;
          end else begin
            buf_we   <= 1'b1;
            buf_addr <= ptr;
            buf_data <= sr;
            ptr      <= AW'(page_step(FN_W'(ptr), PAGE_MASK));
            state    <= ST_WACK;
          end
        end
      end else begin
        unique case (state)
          ST_DACK: if (scl_fall) begin
            if (rw) begin
              shreg <= rd_data;
              cnt   <= '0;
              state <= ST_RDATA;
            end else begin
              state <= ST_WADDR;
            end
          end
          ST_AACK, ST_WACK: if (scl_fall) state <= ST_WDATA;
          ST_RDATA: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                cnt   <= '0;
                ptr   <= AW'(seq_step(FN_W'(ptr), ADDR_MASK));
                state <= ST_RACK;
              end else begin
                shreg <= {shreg[6:0], 1'b1};
              end
            end
          end
          ST_RACK: begin
            if (scl_rise && sda_lvl) begin
              state <= ST_WAIT;
            end else if (scl_fall) begin
              shreg <= rd_data;
              state <= ST_RDATA;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_addr    = ptr;
  assign dev_acking = (state == ST_DACK);
  assign sda_pull   = (state == ST_DACK) || (state == ST_AACK) || (state == ST_WACK) ||
                      ((state == ST_RDATA) && !shreg[7]);

endmodule

// File: rtl/seep_store.sv
module seep_store #(
  parameter int DEPTH        = 256,
  parameter int PAGE_BYTES   = 8,
  parameter int WRITE_CYCLES = 400,
  localparam int AW          = $clog2(DEPTH),
  localparam int PB_W        = $clog2(PAGE_BYTES),
  localparam int BASE_W      = AW - PB_W,
  localparam int CW          = $clog2(WRITE_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          buf_we,
  input  logic [AW-1:0] buf_addr,
  input  logic [7:0]    buf_data,
  input  logic          commit_req,
  input  logic          wp,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          busy,
  output logic          commit_ev
);

  logic [7:0]            mem  [DEPTH];
  logic [7:0]            pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] valid;
  logic [BASE_W-1:0]     base;
  logic [CW-1:0]         left;

  // the top base bit selects the upper half of the array
  wire blocked = wp && base[BASE_W-1];

  assign commit_ev = commit_req && (|valid);
  assign busy      = (left != '0);
  assign rd_data   = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= '0;
      base  <= '0;
      for (int l = 0; l < PAGE_BYTES; l++) pbuf[l] <= '0;
    end else if (clear || commit_ev) begin
      valid <= '0;
    end else if (buf_we) begin
      pbuf[buf_addr[PB_W-1:0]]  <= buf_data;
      valid[buf_addr[PB_W-1:0]] <= 1'b1;
      base                      <= buf_addr[AW-1:PB_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= 8'hFF;
    end else if (commit_ev && !blocked) begin
      for (int l = 0; l < PAGE_BYTES; l++) begin
        if (valid[l]) mem[{base, PB_W'(l)}] <= pbuf[l];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          left <= '0;
    else if (commit_ev)  left <= CW'(WRITE_CYCLES);
    else if (left != '0) left <= left - 1'b1;
  end

endmodule

// File: rtl/serial_eeprom_tgt.sv
module serial_eeprom_tgt #(
  parameter int DEPTH        = 256,
  parameter int PAGE_BYTES   = 8,
  parameter int WRITE_CYCLES = 400,
  parameter int SYNC_STAGES  = 2,
  localparam int AW          = $clog2(DEPTH)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic [2:0] dev_sel_i,
  input  logic       wp_i
);

  logic          scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
  logic          busy, commit_ev, dev_acking, sda_pull;
  logic          buf_we;
  logic [AW-1:0] buf_addr, rd_addr;
  logic [7:0]    buf_data, rd_data;

  seep_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  seep_link #(.DEPTH(DEPTH), .PAGE_BYTES(PAGE_BYTES)) u_link (
    .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .straps(dev_sel_i), .busy(busy),
    .rd_data(rd_data), .rd_addr(rd_addr), .buf_we(buf_we), .buf_addr(buf_addr),
    .buf_data(buf_data), .sda_pull(sda_pull), .dev_acking(dev_acking)
  );

  seep_store #(.DEPTH(DEPTH), .PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)) u_store (
    .clk(clk), .rst_n(rst_n), .clear(start_ev), .buf_we(buf_we), .buf_addr(buf_addr),
    .buf_data(buf_data), .commit_req(stop_ev), .wp(wp_i), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy), .commit_ev(commit_ev)
  );

  assign sda_pull_o = sda_pull;

endmodule

// File: rtl/seep_checker.sv
module seep_checker (
  input logic clk,
  input logic rst_n,
  input logic scl_lvl,
  input logic start_ev,
  input logic stop_ev,
  input logic sda_pull,
  input logic busy,
  input logic commit_ev,
  input logic dev_acking
);

  // R3: own drive holds while SCL stays high (start/stop releases excepted)
  assert_pull_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_lvl && $past(scl_lvl) && !$past(start_ev) && !$past(stop_ev)) |-> $stable(sda_pull));

  // R1: line released right after a stop
  assert_stop_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_pull);

  // R5: array commit only at a stop
  assert_commit_on_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ev |-> stop_ev);

  // R6: commit starts the busy interval
  assert_commit_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ev |=> busy);

  // R6: never a commit during the busy interval
  assert_commit_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ev |-> !busy);

  // R6: device address never acknowledged while busy
  assert_no_ack_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dev_acking |-> !busy);

endmodule

bind serial_eeprom_tgt seep_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .start_ev(start_ev), .stop_ev(stop_ev),
  .sda_pull(sda_pull), .busy(busy), .commit_ev(commit_ev), .dev_acking(dev_acking)
);

// File: tb/serial_eeprom_tgt_tb.sv
module serial_eeprom_tgt_tb;

  localparam int Q  = 6;
  localparam int WC = 400;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tb_scl = 1'b1;
  logic tb_low = 1'b0;
  logic wp = 1'b0;
  logic dut_low;
  wire  sda_bus = ~(tb_low | dut_low);

  int n_chk = 0;
  int n_bad = 0;
  int hi_glitch = 0;
  int cyc = 0;
  logic [7:0] exp_mem [256];

  always #2.5 clk = ~clk;

  serial_eeprom_tgt #(.WRITE_CYCLES(WC)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(tb_scl), .sda_i(sda_bus),
    .sda_pull_o(dut_low), .dev_sel_i(STRAP), .wp_i(wp)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input int got, input int want);
    n_chk++;
    if (got != want) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, want);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input int a, input int i);
    return 8'((a * 37 + i * 11 + 3) % 251);
  endfunction

  task automatic bus_start();
    tb_low = 1'b0; wq(Q);
    tb_scl = 1'b1; wq(Q);
    tb_low = 1'b1; wq(Q);
    tb_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    tb_low = 1'b1; wq(Q);
    tb_scl = 1'b1; wq(Q);
    tb_low = 1'b0; wq(Q);
  endtask

  task automatic put_bit(input logic b);
    wq(2); tb_low = ~b; wq(Q - 2);
    tb_scl = 1'b1; wq(2 * Q);
    tb_scl = 1'b0; wq(Q);
  endtask

  task automatic get_bit(output logic b);
    logic s0, s1;
    tb_low = 1'b0; wq(Q);
    tb_scl = 1'b1; wq(1);
    s0 = sda_bus; wq(Q - 1);
    b = sda_bus; wq(Q - 1);
    s1 = sda_bus; wq(1);
    if (s0 != b || s1 != b) hi_glitch++;
    tb_scl = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(a);
    acked = ~a;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~give_ack);
  endtask

  task automatic do_write(input int addr, input int n, input logic settle);
    logic ak;
    bus_start();
    send_byte(DEV_W, ak); chk("R2 write device ack", ak, 1);
    send_byte(8'(addr), ak); chk("R4 word address ack", ak, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(pat(addr, i), ak); chk("R3 data ack", ak, 1);
    end
    bus_stop();
    if (!(wp && addr >= 128)) begin
      for (int i = 0; i < n; i++)
        exp_mem[(addr / 8) * 8 + ((addr + i) % 8)] = pat(addr, i);
    end
    if (settle) wq(WC + 20);
  endtask

  task automatic seq_read(input int start, input int n, input string req);
    logic ak, b;
    logic [7:0] d;
    bus_start();
    send_byte(DEV_W, ak); chk("R2 device ack", ak, 1);
    send_byte(8'(start), ak); chk("R8 address ack", ak, 1);
    bus_start();
    send_byte(DEV_R, ak); chk("R8 read device ack", ak, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      chk(req, d, exp_mem[(start + i) % 256]);
    end
    get_bit(b); chk("R8 released after nack", b, 1);
    bus_stop();
  endtask

  task automatic cur_read(input int want, input string req);
    logic ak;
    logic [7:0] d;
    bus_start();
    send_byte(DEV_R, ak); chk("R8 current read ack", ak, 1);
    recv_byte(1'b0, d);
    chk(req, d, want);
    bus_stop();
  endtask

  initial begin
    logic ak;
    for (int a = 0; a < 256; a++) exp_mem[a] = 8'hFF;
    wq(10);
    chk("R9 SDA released in reset", sda_bus, 1);
    rst_n = 1'b1;
    wq(10);
    chk("R9 SDA released after reset", sda_bus, 1);

    // R9: current-address read from pointer 0, then whole array erased
    cur_read(8'hFF, "R9 first byte after reset");
    seq_read(0, 256, "R9 erased array");

    // R2: sweep every strap code; only the matching one answers
    for (int v = 0; v < 8; v++) begin
      bus_start();
      send_byte({4'b1010, 3'(v), 1'b0}, ak);
      chk("R2 strap match", ak, (v == STRAP) ? 1 : 0);
      if (!ak) begin
        send_byte(8'h00, ak);
        chk("R2 ignored after mismatch", ak, 0);
      end
      bus_stop();
    end
    bus_start();
    send_byte({4'b1011, STRAP, 1'b0}, ak);
    chk("R2 wrong type nibble", ak, 0);
    bus_stop();

    // R4 single byte, R5 full and wrapping partial pages
    do_write(8'h00, 8, 1'b1);
    do_write(8'h0B, 1, 1'b1);
    do_write(8'h1D, 5, 1'b1);
    do_write(8'hF8, 8, 1'b1);
    // R7: protection blocks upper half only
    wp = 1'b1;
    do_write(8'h88, 4, 1'b1);
    do_write(8'h7C, 4, 1'b1);
    wp = 1'b0;
    do_write(8'h90, 3, 1'b1);

    // R1/R5: repeated start before stop discards the buffered byte
    bus_start();
    send_byte(DEV_W, ak); chk("R1 device ack", ak, 1);
    send_byte(8'h40, ak);
    send_byte(8'h5A, ak);
    bus_start();
    bus_stop();
    bus_start();
    send_byte(DEV_W, ak); chk("R6 no busy without commit", ak, 1);
    bus_stop();

    // R6: busy interval after a commit
    do_write(8'h50, 1, 1'b0);
    bus_start();
    send_byte(DEV_W, ak); chk("R6 no ack while busy", ak, 0);
    bus_stop();
    wq(WC);
    bus_start();
    send_byte(DEV_W, ak); chk("R6 ack after interval", ak, 1);
    bus_stop();

    // R4/R5/R7: read back the written range
    seq_read(0, 160, "R5 readback low range");
    seq_read(8'hF8, 8, "R5 readback top page");
    // R8: wrap at 0xFF and continuation by current-address read
    seq_read(8'hFE, 4, "R8 sequential wrap");
    cur_read(exp_mem[2], "R8 pointer continues");

    chk("R3 SDA steady while SCL high", hi_glitch, 0);
    summary();
    $finish;
  end

endmodule